// File: doc/BRIEF.md
# ECC Error Logger with Countdown Fault Injection

This block sits next to a 64-bit on-chip memory that is protected by single-error-correct, double-error-detect coding. The ECC checker reports each decode outcome on the event inputs: a correctable pulse, an uncorrectable pulse, the failing address, the 64-bit data word and the check-bit syndrome. For each error class the block sets a sticky status flag and records the first failure of that class. The record is held until software acknowledges the flag. A level interrupt is raised whenever a flagged class is not masked. Masking uses separate set and clear strobes.

For testing the error path, software loads a 64-bit flip pattern and a countdown. The block sits on the memory write-data path. Each memory write decrements the armed countdown. On the write that brings the countdown to zero, the block XORs the pattern into the outgoing data, so the stored word carries one flipped bit (correctable) or two flipped bits (uncorrectable). The countdown then disarms. All configuration goes through a 32-bit register port with combinational read data. The ECC coder, the decoder and the memory array are outside this block.

Top module: `ecc_fault_logger`

## Requirements
- R1: After reset the status register (0x04) reads 0, the mask register (0x08) reads 0x000000C0, the ECC control register (0x14) reads 0, the countdown (0x74) reads 0 and irq is low.
- R2: Bit 0 of 0x14 is a read/write ECC-enable flag. While it is 0, error events change neither the status flags nor the capture registers.
- R3: In the status register, bit 6 is the correctable flag and bit 7 is the uncorrectable flag. An enabled event sets its flag on the next clock edge. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an event and a clear reach the same flag in the same cycle, the event wins.
- R4: Correctable capture registers: address at 0x1C, data bits [31:0] at 0x20, data bits [63:32] at 0x24, syndrome at 0x30. Uncorrectable capture registers: address at 0x34, data bits [31:0] at 0x38, data bits [63:32] at 0x3C, syndrome at 0x48. A set of capture registers loads only while its flag is clear, so it keeps the first failure.
- R5: The mask register at 0x08 is read-only, and only bits 6 and 7 are used. Writing 1s to 0x0C clears the matching mask bits. Writing 1s to 0x10 sets them. If both writes hit the same bit, the set wins.
- R6: irq is high exactly when some status flag is set and its mask bit is clear. irq follows one clock edge after the event or register write that changes it.
- R7: Correctable and uncorrectable events in the same cycle set both flags and load both capture sets.
- R8: 0x4C (bits [31:0]) and 0x50 (bits [63:32]) are the read/write 64-bit flip pattern.
- R9: 0x74 holds a 28-bit countdown, and bits [31:28] are dropped on write and read as 0. A nonzero write arms the countdown. Each memory write while armed decrements it. The write that takes it from 1 to 0 leaves with the pattern XORed into its data, and the block is then disarmed. A read of 0x74 returns the current count.
- R10: Offsets without a register (for example 0x00, 0x28, 0x44) read 0 and ignore writes.
- R11: When the block is not armed, memory write data passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| evt_ce | input | 1 | Correctable error event |
| evt_ue | input | 1 | Uncorrectable error event |
| evt_addr | input | 32 | Failing address |
| evt_data | input | 64 | Failing data word |
| evt_syn | input | 8 | Failing syndrome |
| mem_wr | input | 1 | Memory write in this cycle |
| mem_wdata_in | input | 64 | Write data from the coder side |
| mem_wdata_out | output | 64 | Write data to memory, possibly corrupted |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench compares reg_rdata within the same low clock phase in which it sets reg_addr. Register writes, status flags, capture records, mask changes and irq are all due one rising edge after their stimulus, so the bench drives on a falling edge and checks on the next falling edge. The corrupted write word appears in the same cycle as mem_wr and is checked before that cycle's edge. The countdown value is due one edge later and is read back after that edge.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int OFS_STATUS  = 'h04;
  localparam int OFS_MASK    = 'h08;
  localparam int OFS_IEN     = 'h0C;
  localparam int OFS_IDS     = 'h10;
  localparam int OFS_ECCCTL  = 'h14;
  localparam int OFS_CAPBASE = 'h1C;
  localparam int CAP_STRIDE  = 'h18;
  localparam int CAP_ADDR    = 'h00;
  localparam int CAP_DLO     = 'h04;
  localparam int CAP_DHI     = 'h08;
  localparam int CAP_SYN     = 'h14;
  localparam int OFS_PAT     = 'h4C;
  localparam int OFS_COUNT   = 'h74;
  localparam int FLAG_LSB    = 6;
  localparam int N_KINDS     = 2;
  typedef enum logic [0:0] {KIND_CE = 1'b0, KIND_UE = 1'b1} err_kind_e;
endpackage

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              evt,
  input  logic              clr,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic [SYN_W-1:0]  evt_syn,
  output logic              flag,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [SYN_W-1:0]  cap_syn
);
  logic flag_d, load;

  assign load = evt && ecc_en && !flag;

  always_comb begin
    flag_d = flag;
    if (clr)           flag_d = 1'b0;
    if (evt && ecc_en) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_syn  <= '0;
    end else if (load) begin
      cap_addr <= evt_addr;
      cap_data <= evt_data;
      cap_syn  <= evt_syn;
    end
  end

  // R4
  hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> ($stable(cap_addr) && $stable(cap_data) && $stable(cap_syn)));
  // R3
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ecc_en) |=> flag);
  // R2
  gated_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_en && !flag) |=> (!flag && $stable(cap_addr)));
endmodule

// File: rtl/ecc_irq_mask.sv
module ecc_irq_mask #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_bits,
  input  logic [N-1:0] dis_bits,
  input  logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] mask_d;

  always_comb mask_d = (mask & ~en_bits) | dis_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= mask_d;
  end

  assign irq = |(flags & ~mask);

  // R5
  en_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bits[0] && !dis_bits[0]) |=> !mask[0]);
  // R5
  dis_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_bits[N-1] |=> mask[N-1]);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));
endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 28,
  parameter int WORDS  = DATA_W / 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORDS-1:0]  pat_we,
  input  logic              cnt_we,
  input  logic [31:0]       wdata,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] pattern,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  logic [DATA_W-1:0] pat_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              fire;

  assign fire = mem_wr && (count == CNT_ONE);

  always_comb begin
    pat_d = pattern;
    for (int w = 0; w < WORDS; w++)
      if (pat_we[w]) pat_d[w*32 +: 32] = wdata;
  end

  always_comb begin
    cnt_d = count;
    if (cnt_we)                     cnt_d = wdata[CNT_W-1:0];
    else if (mem_wr && count != '0) cnt_d = count - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pattern <= '0;
    else if (|pat_we) pattern <= pat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end

  assign dout = fire ? (din ^ pattern) : din;

  // R9
  fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cnt_we) |=> (count == '0));
  // R9
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && count != '0 && !cnt_we) |=> (count == $past(count) - CNT_ONE));
  // R11
  pass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (dout == din));
endmodule

// File: rtl/ecc_fault_logger.sv
module ecc_fault_logger
  import ecc_log_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 8,
  parameter int CNT_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt_ce,
  input  logic              evt_ue,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] mem_wdata_in,
  output logic [DATA_W-1:0] mem_wdata_out,
  output logic              irq
);
  localparam int WORDS = DATA_W / 32;

  logic                ecc_en, ecc_en_d, ecc_en_we;
  logic [N_KINDS-1:0]  evt_v, flags, clr_v, en_bits, dis_bits, mask;
  logic [ADDR_W-1:0]   cap_addr [N_KINDS];
  logic [DATA_W-1:0]   cap_data [N_KINDS];
  logic [SYN_W-1:0]    cap_syn  [N_KINDS];
  logic [WORDS-1:0]    pat_we;
  logic                cnt_we;
  logic [DATA_W-1:0]   pattern;
  logic [CNT_W-1:0]    count;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int ofs);
    return a == REG_AW'(ofs);
  endfunction

  assign evt_v[KIND_CE] = evt_ce;
  assign evt_v[KIND_UE] = evt_ue;

  assign ecc_en_we = reg_wr && hit(reg_addr, OFS_ECCCTL);
  assign cnt_we    = reg_wr && hit(reg_addr, OFS_COUNT);
  always_comb ecc_en_d = ecc_en_we ? reg_wdata[0] : ecc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecc_en <= 1'b0;
    else        ecc_en <= ecc_en_d;
  end

  genvar k;
  generate
    for (k = 0; k < N_KINDS; k++) begin : g_kind
      assign clr_v[k]    = reg_wr && hit(reg_addr, OFS_STATUS) && reg_wdata[FLAG_LSB+k];
      assign en_bits[k]  = reg_wr && hit(reg_addr, OFS_IEN)    && reg_wdata[FLAG_LSB+k];
      assign dis_bits[k] = reg_wr && hit(reg_addr, OFS_IDS)    && reg_wdata[FLAG_LSB+k];
      ecc_capture_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .evt(evt_v[k]), .clr(clr_v[k]),
        .evt_addr(evt_addr), .evt_data(evt_data), .evt_syn(evt_syn),
        .flag(flags[k]), .cap_addr(cap_addr[k]), .cap_data(cap_data[k]),
        .cap_syn(cap_syn[k]));
    end
    for (k = 0; k < WORDS; k++) begin : g_patwe
      assign pat_we[k] = reg_wr && hit(reg_addr, OFS_PAT + 4*k);
    end
  endgenerate

  ecc_irq_mask #(.N(N_KINDS)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_bits(en_bits), .dis_bits(dis_bits),
    .flags(flags), .mask(mask), .irq(irq));

  ecc_inject #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WORDS(WORDS)) u_inj (
    .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .cnt_we(cnt_we), .wdata(reg_wdata),
    .mem_wr(mem_wr), .din(mem_wdata_in), .dout(mem_wdata_out),
    .pattern(pattern), .count(count));

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFS_STATUS)) reg_rdata[FLAG_LSB +: N_KINDS] = flags;
    if (hit(reg_addr, OFS_MASK))   reg_rdata[FLAG_LSB +: N_KINDS] = mask;
    if (hit(reg_addr, OFS_ECCCTL)) reg_rdata[0] = ecc_en;
    if (hit(reg_addr, OFS_COUNT))  reg_rdata[CNT_W-1:0] = count;
    for (int w = 0; w < WORDS; w++)
      if (hit(reg_addr, OFS_PAT + 4*w)) reg_rdata = pattern[w*32 +: 32];
    for (int t = 0; t < N_KINDS; t++) begin
      if (hit(reg_addr, OFS_CAPBASE + t*CAP_STRIDE + CAP_ADDR)) reg_rdata = 32'(cap_addr[t]);
      if (hit(reg_addr, OFS_CAPBASE + t*CAP_STRIDE + CAP_DLO))  reg_rdata = cap_data[t][31:0];
      if (hit(reg_addr, OFS_CAPBASE + t*CAP_STRIDE + CAP_DHI))  reg_rdata = cap_data[t][63:32];
      if (hit(reg_addr, OFS_CAPBASE + t*CAP_STRIDE + CAP_SYN))  reg_rdata = 32'(cap_syn[t]);
    end
  end

  // R7
  both_kinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ce && evt_ue && ecc_en) |=> (flags == '1));
  // R10
  ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit(reg_addr, 'h00) |-> (reg_rdata == '0));
endmodule

// File: tb/ecc_fault_logger_tb.sv
`timescale 1ns/1ps
module ecc_fault_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        evt_ce, evt_ue;
  logic [31:0] evt_addr;
  logic [63:0] evt_data;
  logic [7:0]  evt_syn;
  logic        mem_wr;
  logic [63:0] mem_wdata_in, mem_wdata_out;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ecc_fault_logger u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_ce(evt_ce), .evt_ue(evt_ue),
    .evt_addr(evt_addr), .evt_data(evt_data), .evt_syn(evt_syn), .mem_wr(mem_wr),
    .mem_wdata_in(mem_wdata_in), .mem_wdata_out(mem_wdata_out), .irq(irq));

  // fields: req(4) op(1: 1=write 0=read) addr(8) data(32) expect(32)
  localparam int NV = 22;
  localparam logic [76:0] VEC [NV] = '{
    {4'd8,  1'b1, 8'h4C, 32'hA5A5_0001, 32'h0},
    {4'd8,  1'b0, 8'h4C, 32'h0,         32'hA5A5_0001},
    {4'd8,  1'b1, 8'h50, 32'h0000_8000, 32'h0},
    {4'd8,  1'b0, 8'h50, 32'h0,         32'h0000_8000},
    {4'd5,  1'b1, 8'h0C, 32'h0000_0040, 32'h0},
    {4'd5,  1'b0, 8'h08, 32'h0,         32'h0000_0080},
    {4'd5,  1'b1, 8'h10, 32'h0000_0040, 32'h0},
    {4'd5,  1'b0, 8'h08, 32'h0,         32'h0000_00C0},
    {4'd5,  1'b1, 8'h08, 32'h0,         32'h0},
    {4'd5,  1'b0, 8'h08, 32'h0,         32'h0000_00C0},
    {4'd10, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {4'd10, 1'b0, 8'h00, 32'h0,         32'h0},
    {4'd10, 1'b1, 8'h28, 32'h1234_5678, 32'h0},
    {4'd10, 1'b0, 8'h28, 32'h0,         32'h0},
    {4'd10, 1'b0, 8'h44, 32'h0,         32'h0},
    {4'd2,  1'b1, 8'h14, 32'h0000_0001, 32'h0},
    {4'd2,  1'b0, 8'h14, 32'h0,         32'h0000_0001},
    {4'd9,  1'b1, 8'h74, 32'hF000_0003, 32'h0},
    {4'd9,  1'b0, 8'h74, 32'h0,         32'h0000_0003},
    {4'd9,  1'b1, 8'h74, 32'h0,         32'h0},
    {4'd9,  1'b0, 8'h74, 32'h0,         32'h0},
    {4'd3,  1'b0, 8'h04, 32'h0,         32'h0}
  };

  function automatic string rq(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string r, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(r, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic event_pulse(input logic ce, input logic ue, input logic [31:0] a,
                             input logic [63:0] d, input logic [7:0] s);
    evt_ce = ce; evt_ue = ue; evt_addr = a; evt_data = d; evt_syn = s;
    @(negedge clk);
    evt_ce = 1'b0; evt_ue = 1'b0;
  endtask

  task automatic mwrite(input string r, input logic [63:0] d, input logic [63:0] exp);
    mem_wr = 1'b1; mem_wdata_in = d; #1;
    chk(r, mem_wdata_out, exp);
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] dw;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_ce = 1'b0; evt_ue = 1'b0; evt_addr = '0; evt_data = '0; evt_syn = '0;
    mem_wr = 1'b0; mem_wdata_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 8'h04, 32'h0);
    rd("R1", 8'h08, 32'hC0);
    rd("R1", 8'h14, 32'h0);
    rd("R1", 8'h74, 32'h0);
    chk("R1", {63'h0, irq}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else rd(rq(int'(VEC[i][76:73])), VEC[i][71:64], VEC[i][31:0]);
    end

    // R3 R4 correctable capture, masked so no irq
    event_pulse(1'b1, 1'b0, 32'h0000_0100, 64'h1111_2222_3333_4444, 8'h5A);
    rd("R3", 8'h04, 32'h40);
    rd("R4", 8'h1C, 32'h100);
    rd("R4", 8'h20, 32'h3333_4444);
    rd("R4", 8'h24, 32'h1111_2222);
    rd("R4", 8'h30, 32'h5A);
    chk("R6", {63'h0, irq}, 64'h0);
    // R6 unmask correctable
    wr(8'h0C, 32'h40);
    chk("R6", {63'h0, irq}, 64'h1);
    // R4 second failure does not overwrite
    event_pulse(1'b1, 1'b0, 32'h0000_0200, 64'hDEAD_BEEF_0000_0000, 8'h11);
    rd("R4", 8'h1C, 32'h100);
    rd("R4", 8'h30, 32'h5A);
    // R3 write 0 leaves, write 1 clears
    wr(8'h04, 32'h0);
    rd("R3", 8'h04, 32'h40);
    wr(8'h04, 32'h40);
    rd("R3", 8'h04, 32'h0);
    chk("R6", {63'h0, irq}, 64'h0);
    // R3 event beats clear in same cycle
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h40;
    event_pulse(1'b1, 1'b0, 32'h0000_0300, 64'h5, 8'h3);
    reg_wr = 1'b0;
    rd("R3", 8'h04, 32'h40);
    wr(8'h04, 32'hC0);
    // R7 both in one cycle
    event_pulse(1'b1, 1'b1, 32'h0000_0AB0, 64'hCAFE_F00D_1234_5678, 8'hC3);
    rd("R7", 8'h04, 32'hC0);
    rd("R7", 8'h34, 32'hAB0);
    rd("R7", 8'h38, 32'h1234_5678);
    rd("R7", 8'h3C, 32'hCAFE_F00D);
    rd("R7", 8'h48, 32'hC3);
    rd("R7", 8'h1C, 32'hAB0);
    // R6 mask correctable again, uncorrectable stays masked
    wr(8'h10, 32'h40);
    chk("R6", {63'h0, irq}, 64'h0);
    wr(8'h0C, 32'h80);
    chk("R6", {63'h0, irq}, 64'h1);
    wr(8'h04, 32'hC0);
    chk("R6", {63'h0, irq}, 64'h0);
    // R2 events ignored while disabled
    wr(8'h14, 32'h0);
    event_pulse(1'b1, 1'b1, 32'h0000_0FFF, 64'h1, 8'h1);
    rd("R2", 8'h04, 32'h0);
    rd("R2", 8'h34, 32'hAB0);
    wr(8'h14, 32'h1);

    // R9 single-bit pattern, third write corrupted
    dw = 64'h0123_4567_89AB_CDEF;
    wr(8'h4C, 32'h0000_0020);
    wr(8'h50, 32'h0);
    mwrite("R11", dw, dw);
    wr(8'h74, 32'h3);
    mwrite("R9", dw, dw);
    rd("R9", 8'h74, 32'h2);
    mwrite("R9", dw, dw);
    mwrite("R9", dw, dw ^ 64'h20);
    rd("R9", 8'h74, 32'h0);
    mwrite("R11", dw, dw);
    // R9 two-bit pattern across both words, count 1
    wr(8'h4C, 32'h1);
    wr(8'h50, 32'h1);
    wr(8'h74, 32'h1);
    mwrite("R9", dw, dw ^ 64'h0000_0001_0000_0001);
    mwrite("R11", dw, dw);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule